// File: doc/BRIEF.md
# Keyboard Wake Sequence Matcher

This block watches the stream of keyboard scan-code bytes handed over by a receiver and raises wake-up requests from it. Each received byte arrives as a one-cycle strobe with its data byte. Four matchers see every byte in the same cycle. Matcher 0 holds a password sequence. Matchers 1, 2 and 3 hold the Power, Sleep and Resume key sequences. Each matcher stores up to eight pattern bytes and a length of its own. When a byte completes a matcher's sequence, that matcher's output pulses for one cycle.

A separate any-key mode is controlled by a level input. While it is set, every received byte gives a pulse on its own output. The pattern bytes and lengths are loaded through a simple write port. The port takes a matcher select, an address and a data byte. A write to a matcher throws away any partial match it was holding.

Top module: `kbwake_seq_top`

## Requirements
- R1: After reset both outputs are low, every match position is 0, every length is 8, and every pattern byte is 0x00.
- R2: A write with `cfg_we` high goes to the matcher chosen by `cfg_sel` (0 password, 1 Power, 2 Sleep, 3 Resume). Addresses 0 to 7 store `cfg_wdata` as the pattern byte at that position. Addresses 8 to 15 set the length to `cfg_wdata[2:0]` + 1.
- R3: When a byte completes a matcher's sequence, bit `cfg_sel`-index of `wake_seq` is high for the one cycle that follows the byte's strobe. The matcher then returns to position 0, so the next match needs the whole sequence again.
- R4: A byte that does not match at the current position restarts the matcher. If that byte equals pattern byte 0, the matcher moves to position 1. Otherwise it moves to position 0.
- R5: All four matchers examine every byte in the same cycle. One byte can complete several sequences at once, and then several bits of `wake_seq` pulse together.
- R6: Lengths from 1 to 8 are honoured. With length 1, every byte equal to pattern byte 0 gives a pulse, including bytes that arrive back to back.
- R7: A write to a matcher resets only that matcher's position. If the write and a byte strobe fall in the same cycle, that matcher ignores the byte and gives no pulse in the next cycle. The other matchers handle the byte as usual.
- R8: While `anykey_en` is high, every byte strobe gives a one-cycle `wake_any` pulse in the next cycle. While `anykey_en` is low, `wake_any` stays low.
- R9: In cycles with `byte_vld` low and no write, `byte_dat` is ignored and all match positions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Strobe: a received byte is present this cycle |
| byte_dat | input | 8 | Received scan-code byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target matcher: 0 password, 1 Power, 2 Sleep, 3 Resume |
| cfg_addr | input | 4 | 0 to 7 select a pattern byte; 8 to 15 select the length |
| cfg_wdata | input | 8 | Write data |
| anykey_en | input | 1 | Enables the any-key wake mode |
| wake_seq | output | 4 | One-cycle match pulses, one bit per matcher |
| wake_any | output | 1 | One-cycle any-key wake pulse |

## Verification
The assertions check rules that hold on every cycle. A sequence pulse needs a byte in the previous cycle, and the matcher that pulses is then at position 0. A write blocks the next pulse of its own matcher. Idle cycles leave every position unchanged, and `wake_any` only follows a byte taken while the mode is enabled. The bench scenarios are the only way to show which byte streams are actually recognised. That covers the reset pattern contents, re-arming on the first pattern byte, different lengths, several sequences completing on one byte, and the effect of a write arriving mid-sequence.

// File: rtl/kbwake_pkg.sv
package kbwake_pkg;
  // byte width of the received stream
  localparam int unsigned KB_BYTE_W  = 8;
  // deepest sequence (power of two)
  localparam int unsigned KB_SEQ_MAX = 8;
  // number of concurrent sequence matchers
  localparam int unsigned KB_NSEQ    = 4;

  typedef enum logic [1:0] {
    SEQ_PASSWORD = 2'd0,
    SEQ_POWER    = 2'd1,
    SEQ_SLEEP    = 2'd2,
    SEQ_RESUME   = 2'd3
  } kb_seq_e;
endpackage

// File: rtl/kbwake_matcher.sv
module kbwake_matcher #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned SEQ_MAX = 8,
  localparam int unsigned PW     = $clog2(SEQ_MAX),
  localparam int unsigned AW     = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              hit_o,
  output logic [PW-1:0]     pos_o
);
  logic [BYTE_W-1:0] pat_q [SEQ_MAX];
  logic [PW-1:0]     len_m1_q;
  logic [PW-1:0]     pos_q;
  logic              hit_q;

  // named internal events
  logic              cur_eq;
  logic              first_eq;
  logic              at_last;
  logic              step_hit;
  logic [PW-1:0]     step_pos;

  // Next position after one byte: {hit, new position}
  function automatic logic [PW:0] advance(input logic [PW-1:0] pos,
                                          input logic eq_cur,
                                          input logic eq_first,
                                          input logic last);
    if (eq_cur && last)  return {1'b1, {PW{1'b0}}};
    if (eq_cur)          return {1'b0, pos + PW'(1)};
    if (eq_first)        return {1'b0, PW'(1)};
    return {1'b0, {PW{1'b0}}};
  endfunction

  assign cur_eq   = (byte_dat == pat_q[pos_q]);
  assign first_eq = (byte_dat == pat_q[0]);
  assign at_last  = (pos_q == len_m1_q);
  assign {step_hit, step_pos} = advance(pos_q, cur_eq, first_eq, at_last);

  genvar gi;
  generate
    for (gi = 0; gi < SEQ_MAX; gi++) begin : g_pat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          pat_q[gi] <= '0;
        else if (wr_en && !wr_addr[AW-1] && (wr_addr[PW-1:0] == PW'(gi)))
          pat_q[gi] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      len_m1_q <= PW'(SEQ_MAX - 1);
    else if (wr_en && wr_addr[AW-1])
      len_m1_q <= wr_data[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      hit_q <= 1'b0;
    end else if (wr_en) begin
      pos_q <= '0;
      hit_q <= 1'b0;
    end else if (byte_vld) begin
      pos_q <= step_pos;
      hit_q <= step_hit;
    end else begin
      hit_q <= 1'b0;
    end
  end

  assign hit_o = hit_q;
  assign pos_o = pos_q;
endmodule

// File: rtl/kbwake_anykey.sv
module kbwake_anykey (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_vld,
  input  logic enable,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= byte_vld & enable;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/kbwake_seq_top.sv
module kbwake_seq_top
  import kbwake_pkg::*;
#(
  parameter int unsigned BYTE_W  = KB_BYTE_W,
  parameter int unsigned SEQ_MAX = KB_SEQ_MAX,
  parameter int unsigned NSEQ    = KB_NSEQ,
  localparam int unsigned PW     = $clog2(SEQ_MAX),
  localparam int unsigned AW     = PW + 1,
  localparam int unsigned SW     = $clog2(NSEQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_sel,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              anykey_en,
  output logic [NSEQ-1:0]   wake_seq,
  output logic              wake_any
);
  // match positions of all matchers, brought out for the checker
  logic [NSEQ*PW-1:0] pos_flat;
  // per-matcher write strobes
  logic [NSEQ-1:0]    sel_we;

  genvar gs;
  generate
    for (gs = 0; gs < NSEQ; gs++) begin : g_seq
      assign sel_we[gs] = cfg_we && (cfg_sel == SW'(gs));

      kbwake_matcher #(
        .BYTE_W (BYTE_W),
        .SEQ_MAX(SEQ_MAX)
      ) match_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_vld(byte_vld),
        .byte_dat(byte_dat),
        .wr_en   (sel_we[gs]),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .hit_o   (wake_seq[gs]),
        .pos_o   (pos_flat[gs*PW +: PW])
      );
    end
  endgenerate

  kbwake_anykey any_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_vld(byte_vld),
    .enable  (anykey_en),
    .pulse_o (wake_any)
  );
endmodule

// File: rtl/kbwake_chk.sv
module kbwake_chk #(
  parameter int unsigned NSEQ = 4,
  parameter int unsigned PW   = 3,
  parameter int unsigned SW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             cfg_we,
  input logic [SW-1:0]    cfg_sel,
  input logic             anykey_en,
  input logic [NSEQ-1:0]  wake_seq,
  input logic             wake_any,
  input logic [NSEQ*PW-1:0] pos_flat
);
  genvar gc;
  generate
    for (gc = 0; gc < NSEQ; gc++) begin : g_chk
      assert_hit_needs_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_seq[gc] |-> $past(byte_vld));

      assert_pos_zero_after_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_seq[gc] |-> (pos_flat[gc*PW +: PW] == '0));

      assert_cfg_blocks_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_sel == SW'(gc))) |=> !wake_seq[gc]);
    end
  endgenerate

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !cfg_we) |=> $stable(pos_flat));

  assert_any_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any |-> $past(byte_vld && anykey_en));

  assert_any_follows_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && anykey_en) |=> wake_any);
endmodule

bind kbwake_seq_top kbwake_chk #(.NSEQ(NSEQ), .PW(PW), .SW(SW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .byte_vld (byte_vld),
  .cfg_we   (cfg_we),
  .cfg_sel  (cfg_sel),
  .anykey_en(anykey_en),
  .wake_seq (wake_seq),
  .wake_any (wake_any),
  .pos_flat (pos_flat)
);

// File: tb/kbwake_seq_top_tb_top.sv
module kbwake_seq_top_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_dat = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       anykey_en = 1'b0;
  logic [3:0] wake_seq;
  logic       wake_any;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] got;
  logic       got_any;

  always #(CLK_P/2) clk = ~clk;

  kbwake_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .anykey_en(anykey_en), .wake_seq(wake_seq), .wake_any(wake_any)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one byte; outputs captured in the cycle after its strobe
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1; byte_dat = b;
    @(negedge clk);
    byte_vld = 1'b0; byte_dat = 8'hEE;
    got = wake_seq; got_any = wake_any;
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset_defaults;  // R1
    check("R1 reset outputs", {wake_any, wake_seq}, 5'b0);
    for (int i = 0; i < 7; i++) begin
      send(8'h00);
      check("R1 zero pattern partial", {got_any, got}, 5'b0);
    end
    send(8'h00);
    check("R1 default length 8 zeros", {got_any, got}, 5'b01111);
  endtask

  task automatic t_password;  // R2 R3
    wr(2'd0, 4'd0, 8'hA1); wr(2'd0, 4'd1, 8'hB2); wr(2'd0, 4'd2, 8'hC3);
    wr(2'd0, 4'd8, 8'h02);
    send(8'hA1); check("R2 first byte", {1'b0, got}, 5'b0);
    send(8'hB2); check("R2 second byte", {1'b0, got}, 5'b0);
    send(8'hC3); check("R3 password match", {got_any, got}, 5'b00001);
    send(8'hB2); send(8'hC3);
    check("R3 restart after match", {1'b0, got}, 5'b0);
  endtask

  task automatic t_mismatch;  // R4
    send(8'hA1); send(8'hB2); send(8'hA1); send(8'hB2); send(8'hC3);
    check("R4 rearm on first byte after mid mismatch", {1'b0, got}, 5'b00001);
    send(8'hA1); send(8'hA1); send(8'hB2); send(8'hC3);
    check("R4 repeated first byte", {1'b0, got}, 5'b00001);
    send(8'hA1); send(8'h55); send(8'hB2); send(8'hC3);
    check("R4 foreign byte restarts", {1'b0, got}, 5'b0);
  endtask

  task automatic t_concurrent;  // R5
    wr(2'd1, 4'd0, 8'hB2); wr(2'd1, 4'd1, 8'hC3); wr(2'd1, 4'd9, 8'h01);
    wr(2'd2, 4'd0, 8'hC3); wr(2'd2, 4'd15, 8'h00);
    send(8'hA1); send(8'hB2); send(8'hC3);
    check("R5 three sequences on one byte", {1'b0, got}, 5'b00111);
  endtask

  task automatic t_lengths;  // R6
    send(8'hC3); check("R6 length 1 first", {1'b0, got}, 5'b00100);
    send(8'hC3); check("R6 length 1 back to back", {1'b0, got}, 5'b00100);
    for (int i = 0; i < 8; i++) wr(2'd3, 4'(i), 8'(i + 1));
    for (int i = 0; i < 7; i++) begin
      send(8'(i + 1));
      check("R6 length 8 partial", {1'b0, got[3]}, 5'b0);
    end
    send(8'h08); check("R6 length 8 match", {1'b0, got}, 5'b01000);
  endtask

  task automatic t_cfg_reset;  // R7
    send(8'hA1); send(8'hB2);
    wr(2'd0, 4'd2, 8'hC3);
    send(8'hC3); check("R7 own write drops progress", {1'b0, got}, 5'b00110);
    send(8'hA1); send(8'hB2);
    wr(2'd1, 4'd1, 8'hC3);
    send(8'hC3); check("R7 other matcher untouched", {1'b0, got}, 5'b00101);
    send(8'hA1); send(8'hB2);
    @(negedge clk);
    byte_vld = 1'b1; byte_dat = 8'hC3;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_addr = 4'd2; cfg_wdata = 8'hC3;
    @(negedge clk);
    byte_vld = 1'b0; cfg_we = 1'b0;
    check("R7 write wins over same-cycle byte", {1'b0, wake_seq}, 5'b00110);
  endtask

  task automatic t_idle;  // R9
    send(8'hA1);
    @(negedge clk); byte_dat = 8'hB2;
    @(negedge clk); byte_dat = 8'h55;
    @(negedge clk); byte_dat = 8'hC3;
    @(negedge clk);
    check("R9 idle bytes give no pulse", {wake_any, wake_seq}, 5'b0);
    send(8'hB2); send(8'hC3);
    check("R9 progress held over idle", {1'b0, got}, 5'b00111);
  endtask

  task automatic t_anykey;  // R8
    anykey_en = 1'b1;
    send(8'h11); check("R8 any key pulse", {got_any, got}, 5'b10000);
    send(8'h22); check("R8 any key second", {got_any, got}, 5'b10000);
    @(negedge clk);
    check("R8 pulse one cycle", {wake_any, 4'b0}, 5'b0);
    anykey_en = 1'b0;
    send(8'h33); check("R8 disabled", {got_any, got}, 5'b0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {wake_any, wake_seq}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_defaults();
    t_password();
    t_mismatch();
    t_concurrent();
    t_lengths();
    t_cfg_reset();
    t_idle();
    t_anykey();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule